// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a processor core, together with the shadow copies that each processor mode keeps. A 5-bit mode value is decoded into one of seven banks: user, fast interrupt, interrupt, supervisor, abort, undefined, and a dummy bank for mode values that have no meaning. The live registers always belong to the current mode. When the mode changes, the registers of the outgoing bank are saved and those of the incoming bank are restored, all on the same clock edge.

The block has one read port and one write port. Each port names a mode and a register index. If the named mode decodes to the current bank, the port reaches the live register. Otherwise the port reaches that bank's saved copy. This lets exception entry code, or a debugger, inspect and patch the registers of another mode without switching to it. Register 15 is plain storage here. Program counter handling is left to the surrounding core.

Top module: `mode_bank_rf`

## Requirements
- R1: After reset the current mode is 19 (supervisor) and every register in every bank reads zero.
- R2: Mode values 0 to 3 and 16 to 19 decode to the user, fast interrupt, interrupt and supervisor banks in that order. Mode 23 decodes to the abort bank and mode 27 to the undefined bank. Every other 5-bit value decodes to the dummy bank.
- R3: Registers 0 to 7 and register 15 exist once. A read or write of them through any mode reaches the same storage.
- R4: The fast interrupt bank has private copies of registers 8 to 14.
- R5: The user, interrupt, supervisor, abort and undefined banks share one set of registers 8 to 12. Each of these banks has private copies of registers 13 and 14.
- R6: A port access whose mode decodes to the current bank reaches the live register. An access whose mode decodes to a different bank reaches that bank's saved copy.
- R7: A mode change between two mode values of the same bank saves and restores nothing, so all registers keep their values.
- R8: Entering the dummy bank sets registers 8 to 14 to zero. While another bank is current, dummy-mode reads of registers 8 to 14 return zero and dummy-mode writes to them are ignored.
- R9: A mode change requested with `mode_we_i` takes effect at the next clock edge. A write in the same cycle is routed as though the new mode were already current.
- R10: Leaving the dummy bank for a bank other than fast interrupt keeps registers 8 to 12 at the values they held in the dummy bank. Registers 13 and 14 are restored from the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load a new current mode |
| mode_i | input | 5 | New mode value |
| wr_en_i | input | 1 | Write enable |
| wr_mode_i | input | 5 | Mode whose view the write uses |
| wr_idx_i | input | 4 | Register index to write |
| wr_data_i | input | 32 | Write data |
| rd_mode_i | input | 5 | Mode whose view the read uses |
| rd_idx_i | input | 4 | Register index to read |
| rd_data_o | output | 32 | Read data, combinational from the stored state |
| cur_mode_o | output | 5 | Current mode |

## Verification
The assertions check these properties on every cycle:
- the mode register's load and hold behaviour;
- that the unbanked registers read the same through any mode;
- the zero view of the dummy bank from outside it;
- the zeroing of registers 8 to 14 on dummy entry;
- the unchanged live state across a same-bank mode change.

Other behaviours can only be shown by the bench's scenarios, which compare against a bank-array reference model:
- that saved values survive a round trip through the fast interrupt bank;
- that the shared copy of registers 8 to 12 is the one reached while the fast interrupt bank is current;
- what stale state is left behind after visits to the dummy bank;
- how a write is routed in the cycle of a mode change.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_DUM
  } bank_e;

  typedef enum logic [2:0] {
    SEL_LIVE, SEL_SHARED, SEL_FIQ, SEL_PRIV, SEL_ZERO
  } sel_e;

  localparam int unsigned FIQ_N  = 7;  // r8..r14
  localparam int unsigned SHR_N  = 5;  // r8..r12
  localparam int unsigned PRIV_B = 5;  // banks with private r13/r14
  localparam int unsigned PRIV_N = 2 * PRIV_B;

  function automatic logic [2:0] priv_slot(bank_e b);
    case (b)
      BK_IRQ:  return 3'd1;
      BK_SVC:  return 3'd2;
      BK_ABT:  return 3'd3;
      BK_UND:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
  import mbrf_pkg::*;
#(
  parameter int unsigned MODE_W = 5
) (
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  always_comb begin
    case (mode_i)
      MODE_W'(0), MODE_W'(16): bank_o = BK_USR;
      MODE_W'(1), MODE_W'(17): bank_o = BK_FIQ;
      MODE_W'(2), MODE_W'(18): bank_o = BK_IRQ;
      MODE_W'(3), MODE_W'(19): bank_o = BK_SVC;
      MODE_W'(23):             bank_o = BK_ABT;
      MODE_W'(27):             bank_o = BK_UND;
      default:                 bank_o = BK_DUM;
    endcase
  end
endmodule

// File: rtl/mbrf_route.sv
module mbrf_route
  import mbrf_pkg::*;
(
  input  bank_e      acc_bank_i,
  input  bank_e      cur_bank_i,
  input  logic [3:0] idx_i,
  output sel_e       sel_o,
  output logic [3:0] slot_o
);
  logic banked;
  assign banked = (idx_i >= 4'd8) && (idx_i <= 4'd14);

  always_comb begin
    sel_o  = SEL_LIVE;
    slot_o = '0;
    if (banked && (acc_bank_i != cur_bank_i)) begin
      case (acc_bank_i)
        BK_FIQ: begin
          sel_o  = SEL_FIQ;
          slot_o = idx_i - 4'd8;
        end
        BK_DUM: sel_o = SEL_ZERO;
        default: begin
          if (idx_i >= 4'd13) begin
            sel_o  = SEL_PRIV;
            slot_o = {priv_slot(acc_bank_i), 1'b0} + (idx_i - 4'd13);
          end else if (cur_bank_i == BK_FIQ) begin
            // shared r8..r12 are parked while the fast interrupt bank is live
            sel_o  = SEL_SHARED;
            slot_o = idx_i - 4'd8;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mode_bank_rf.sv
module mode_bank_rf
  import mbrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [MODE_W-1:0] rd_mode_i,
  input  logic [3:0]        rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [MODE_W-1:0] cur_mode_o
);
  localparam int unsigned NREG = 16;
  localparam int unsigned NMAP = 4;
  localparam logic [MODE_W-1:0] RST_MODE = MODE_W'(19);

  logic [MODE_W-1:0] mode_q, nxt_mode;
  logic [NREG-1:0][DATA_W-1:0]   live_q, live_s, live_d;
  logic [SHR_N-1:0][DATA_W-1:0]  shr_q, shr_s, shr_d;
  logic [FIQ_N-1:0][DATA_W-1:0]  fiq_q, fiq_s, fiq_d;
  logic [PRIV_N-1:0][DATA_W-1:0] prv_q, prv_s, prv_d;

  assign nxt_mode = mode_we_i ? mode_i : mode_q;

  // bank decode for current, next, read and write modes
  logic [NMAP-1:0][MODE_W-1:0] map_mode;
  bank_e map_bank [NMAP];
  assign map_mode = {wr_mode_i, rd_mode_i, nxt_mode, mode_q};

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    mbrf_bank_map #(.MODE_W(MODE_W)) u_map (
      .mode_i (map_mode[g]),
      .bank_o (map_bank[g])
    );
  end

  bank_e cur_bank, nxt_bank, rd_bank, wr_bank;
  assign cur_bank = map_bank[0];
  assign nxt_bank = map_bank[1];
  assign rd_bank  = map_bank[2];
  assign wr_bank  = map_bank[3];

  sel_e rd_sel, wr_sel;
  logic [3:0] rd_slot, wr_slot;

  mbrf_route u_rt_rd (
    .acc_bank_i (rd_bank),
    .cur_bank_i (cur_bank),
    .idx_i      (rd_idx_i),
    .sel_o      (rd_sel),
    .slot_o     (rd_slot)
  );

  mbrf_route u_rt_wr (
    .acc_bank_i (wr_bank),
    .cur_bank_i (nxt_bank),
    .idx_i      (wr_idx_i),
    .sel_o      (wr_sel),
    .slot_o     (wr_slot)
  );

  // save outgoing bank, restore incoming bank
  always_comb begin
    live_s = live_q;
    shr_s  = shr_q;
    fiq_s  = fiq_q;
    prv_s  = prv_q;
    if (cur_bank != nxt_bank) begin
      if (cur_bank == BK_FIQ) begin
        for (int i = 0; i < FIQ_N; i++) fiq_s[i] = live_q[8+i];
      end else if (cur_bank != BK_DUM) begin
        if (nxt_bank == BK_FIQ) begin
          for (int i = 0; i < SHR_N; i++) shr_s[i] = live_q[8+i];
        end
        prv_s[{priv_slot(cur_bank), 1'b0}]  = live_q[13];
        prv_s[{priv_slot(cur_bank), 1'b1}]  = live_q[14];
      end

      if (nxt_bank == BK_FIQ) begin
        for (int i = 0; i < FIQ_N; i++) live_s[8+i] = fiq_q[i];
      end else if (nxt_bank == BK_DUM) begin
        for (int i = 0; i < FIQ_N; i++) live_s[8+i] = '0;
      end else begin
        if (cur_bank == BK_FIQ) begin
          for (int i = 0; i < SHR_N; i++) live_s[8+i] = shr_q[i];
        end
        live_s[13] = prv_q[{priv_slot(nxt_bank), 1'b0}];
        live_s[14] = prv_q[{priv_slot(nxt_bank), 1'b1}];
      end
    end
  end

  // port write applied on top of the post-switch state
  always_comb begin
    live_d = live_s;
    shr_d  = shr_s;
    fiq_d  = fiq_s;
    prv_d  = prv_s;
    if (wr_en_i) begin
      case (wr_sel)
        SEL_LIVE:   live_d[wr_idx_i]    = wr_data_i;
        SEL_SHARED: shr_d[wr_slot[2:0]] = wr_data_i;
        SEL_FIQ:    fiq_d[wr_slot[2:0]] = wr_data_i;
        SEL_PRIV:   prv_d[wr_slot]      = wr_data_i;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RST_MODE;
      live_q <= '0;
      shr_q  <= '0;
      fiq_q  <= '0;
      prv_q  <= '0;
    end else begin
      mode_q <= nxt_mode;
      live_q <= live_d;
      shr_q  <= shr_d;
      fiq_q  <= fiq_d;
      prv_q  <= prv_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_SHARED: rd_data_o = shr_q[rd_slot[2:0]];
      SEL_FIQ:    rd_data_o = fiq_q[rd_slot[2:0]];
      SEL_PRIV:   rd_data_o = prv_q[rd_slot];
      SEL_ZERO:   rd_data_o = '0;
      default:    rd_data_o = live_q[rd_idx_i];
    endcase
  end

  assign cur_mode_o = mode_q;
endmodule

// File: rtl/mbrf_checker.sv
module mbrf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MODE_W = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mode_we_i,
  input logic [MODE_W-1:0]      mode_i,
  input logic                   wr_en_i,
  input logic [3:0]             wr_idx_i,
  input logic [MODE_W-1:0]      rd_mode_i,
  input logic [3:0]             rd_idx_i,
  input logic [DATA_W-1:0]      rd_data_o,
  input logic [MODE_W-1:0]      cur_mode_o,
  input logic [15:0][DATA_W-1:0] live_q
);
  function automatic int ck_bank(logic [MODE_W-1:0] m);
    int v;
    v = int'(m);
    if (v == 23) return 4;
    if (v == 27) return 5;
    if (v < 4) return v;
    if (v >= 16 && v < 20) return v - 16;
    return 6;
  endfunction

  logic wr_hi;
  assign wr_hi = wr_en_i && (wr_idx_i >= 4'd8) && (wr_idx_i <= 4'd14);

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> cur_mode_o == $past(mode_i)); // R9

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(cur_mode_o)); // R9

  AST_UNBANKED_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i < 4'd8 || rd_idx_i == 4'd15) |-> rd_data_o == live_q[rd_idx_i]); // R3

  AST_DUMMY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_bank(rd_mode_i) == 6 && ck_bank(cur_mode_o) != 6 &&
     rd_idx_i >= 4'd8 && rd_idx_i <= 4'd14) |-> rd_data_o == '0); // R8

  AST_DUMMY_ENTRY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && ck_bank(mode_i) == 6 && ck_bank(cur_mode_o) != 6 && !wr_hi)
    |=> live_q[14:8] == '0); // R8

  AST_SAME_BANK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && ck_bank(mode_i) == ck_bank(cur_mode_o) && !wr_en_i)
    |=> $stable(live_q)); // R7
endmodule

bind mode_bank_rf mbrf_checker #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_we_i  (mode_we_i),
  .mode_i     (mode_i),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .rd_mode_i  (rd_mode_i),
  .rd_idx_i   (rd_idx_i),
  .rd_data_o  (rd_data_o),
  .cur_mode_o (cur_mode_o),
  .live_q     (live_q)
);

// File: tb/mode_bank_rf_bench.sv
module mode_bank_rf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int MW = 5;
  localparam int MAX_CYC = 200000;
  localparam int N_RAND = 3000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_we_i = 1'b0;
  logic [MW-1:0] mode_i = '0;
  logic          wr_en_i = 1'b0;
  logic [MW-1:0] wr_mode_i = '0;
  logic [3:0]    wr_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [MW-1:0] rd_mode_i = '0;
  logic [3:0]    rd_idx_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [MW-1:0] cur_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_bank_rf u_mode_bank_rf (
    .clk_i (clk), .rst_ni (rst_ni), .mode_we_i (mode_we_i), .mode_i (mode_i),
    .wr_en_i (wr_en_i), .wr_mode_i (wr_mode_i), .wr_idx_i (wr_idx_i),
    .wr_data_i (wr_data_i), .rd_mode_i (rd_mode_i), .rd_idx_i (rd_idx_i),
    .rd_data_o (rd_data_o), .cur_mode_o (cur_mode_o)
  );

  // reference: live registers plus a full per-bank save area
  // banks: 0 usr 1 fiq 2 irq 3 svc 4 abt 5 und 6 dummy
  logic [DW-1:0] m_live [16];
  logic [DW-1:0] m_save [7][16];
  logic [MW-1:0] m_mode;

  function automatic int bank_of(logic [MW-1:0] m);
    case (m)
      5'd0, 5'd16: return 0;
      5'd1, 5'd17: return 1;
      5'd2, 5'd18: return 2;
      5'd3, 5'd19: return 3;
      5'd23:       return 4;
      5'd27:       return 5;
      default:     return 6;
    endcase
  endfunction

  function automatic bit userlike(int b);
    return b != 1 && b != 6;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 7; b++) for (int r = 0; r < 16; r++) m_save[b][r] = '0;
    for (int r = 0; r < 16; r++) m_live[r] = '0;
    m_mode = 5'd19;
  endtask

  function automatic logic [DW-1:0] model_read(logic [MW-1:0] m, int r);
    int ab, cb;
    ab = bank_of(m);
    cb = bank_of(m_mode);
    if (ab == cb || r < 8 || r == 15) return m_live[r];
    if (ab == 6) return '0;
    if (ab == 1) return m_save[1][r];
    if (r >= 13) return m_save[ab][r];
    if (cb == 1) return m_save[0][r];
    return m_live[r];
  endfunction

  task automatic model_step(bit we, logic [MW-1:0] nm, bit wen,
                            logic [MW-1:0] wm, int wi, logic [DW-1:0] wd);
    int ob, nb, wb;
    if (we) begin
      ob = bank_of(m_mode);
      nb = bank_of(nm);
      if (ob != nb) begin
        if (ob == 1) for (int r = 8; r < 15; r++) m_save[1][r] = m_live[r];
        else if (ob != 6) begin
          if (nb == 1) for (int r = 8; r < 13; r++) m_save[0][r] = m_live[r];
          m_save[ob][13] = m_live[13];
          m_save[ob][14] = m_live[14];
        end
        if (nb == 1) for (int r = 8; r < 15; r++) m_live[r] = m_save[1][r];
        else if (nb == 6) for (int r = 8; r < 15; r++) m_live[r] = '0;
        else begin
          if (ob == 1) for (int r = 8; r < 13; r++) m_live[r] = m_save[0][r];
          m_live[13] = m_save[nb][13];
          m_live[14] = m_save[nb][14];
        end
      end
      m_mode = nm;
    end
    if (wen) begin
      wb = bank_of(wm);
      nb = bank_of(m_mode);
      if (wb == nb || wi < 8 || wi == 15) m_live[wi] = wd;
      else if (wb == 1) m_save[1][wi] = wd;
      else if (userlike(wb)) begin
        if (wi >= 13) m_save[wb][wi] = wd;
        else if (nb == 1) m_save[0][wi] = wd;
        else m_live[wi] = wd;
      end
    end
  endtask

  // one clock: drive, check read and mode before the edge, then step the model
  task automatic cyc(bit we, logic [MW-1:0] nm, bit wen, logic [MW-1:0] wm,
                     int wi, logic [DW-1:0] wd, logic [MW-1:0] rm, int ri,
                     string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    mode_we_i = we; mode_i = nm; wr_en_i = wen; wr_mode_i = wm;
    wr_idx_i = 4'(wi); wr_data_i = wd; rd_mode_i = rm; rd_idx_i = 4'(ri);
    #1;
    exp = model_read(rm, ri);
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s: read mode %0d r%0d actual %h expected %h", tag, rm, ri, rd_data_o, exp);
    end
    checks++;
    if (cur_mode_o !== m_mode) begin
      errors++;
      $display("FAIL %s: mode actual %0d expected %0d", tag, cur_mode_o, m_mode);
    end
    @(posedge clk);
    model_step(we, nm, wen, wm, wi, wd);
  endtask

  task automatic rd(logic [MW-1:0] m, int r, string tag);
    cyc(1'b0, '0, 1'b0, '0, 0, '0, m, r, tag);
  endtask

  task automatic wr(logic [MW-1:0] m, int r, logic [DW-1:0] d, string tag);
    cyc(1'b0, '0, 1'b1, m, r, d, m, r, tag);
  endtask

  task automatic sw(logic [MW-1:0] m, string tag);
    cyc(1'b1, m, 1'b0, '0, 0, '0, m, 13, tag);
  endtask

  logic [MW-1:0] pick [14] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18,
                               5'd19, 5'd23, 5'd27, 5'd4, 5'd31, 5'd28, 5'd10};

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: reset state across banks
    for (int r = 0; r < 16; r++) rd(5'd19, r, "R1");
    rd(5'd17, 9, "R1");
    rd(5'd27, 14, "R1");

    // R3: unbanked registers, one copy for every mode
    for (int r = 0; r < 16; r++) wr(5'd19, r, 32'hA000_0000 + r, "R3");
    rd(5'd17, 3, "R3");
    rd(5'd31, 15, "R3");

    // R5/R6: leave supervisor for user, view supervisor copy from outside
    sw(5'd16, "R5");
    rd(5'd16, 13, "R5");
    rd(5'd19, 13, "R6");
    rd(5'd16, 8, "R5");
    wr(5'd16, 14, 32'h1111_1414, "R5");

    // R4: fast interrupt private r8..r14
    sw(5'd17, "R4");
    rd(5'd17, 8, "R4");
    rd(5'd16, 8, "R6");
    wr(5'd17, 8, 32'hF1F1_0008, "R4");
    wr(5'd16, 10, 32'h5555_0010, "R6");
    sw(5'd0, "R2");
    rd(5'd0, 8, "R4");
    rd(5'd0, 10, "R6");
    rd(5'd1, 8, "R4");

    // R7: same-bank mode change
    sw(5'd16, "R7");
    rd(5'd16, 14, "R7");
    sw(5'd3, "R7");
    sw(5'd19, "R7");
    rd(5'd19, 13, "R7");

    // R2: abort and undefined banks keep separate r13
    wr(5'd23, 13, 32'hABAB_0013, "R2");
    wr(5'd27, 13, 32'hDEDE_0013, "R2");
    rd(5'd23, 13, "R2");
    rd(5'd27, 13, "R2");
    sw(5'd23, "R2");
    rd(5'd23, 13, "R2");

    // R8/R10: dummy entry, writes inside, exit to user
    wr(5'd23, 9, 32'h9999_0009, "R8");
    sw(5'd5, "R8");
    rd(5'd5, 9, "R8");
    rd(5'd5, 14, "R8");
    wr(5'd5, 9, 32'hD0D0_0009, "R10");
    sw(5'd16, "R10");
    rd(5'd16, 9, "R10");
    rd(5'd16, 13, "R10");
    rd(5'd31, 10, "R8");
    wr(5'd31, 10, 32'hBAD0_0010, "R8");
    rd(5'd16, 10, "R8");
    rd(5'd31, 10, "R8");

    // R9: write during a mode change uses the new mapping
    cyc(1'b1, 5'd17, 1'b1, 5'd17, 8, 32'h7777_0008, 5'd17, 8, "R9");
    rd(5'd17, 8, "R9");
    cyc(1'b1, 5'd16, 1'b1, 5'd17, 11, 32'h7777_0011, 5'd16, 11, "R9");
    rd(5'd17, 11, "R9");
    cyc(1'b1, 5'd17, 1'b1, 5'd16, 9, 32'h6666_0009, 5'd16, 9, "R9");
    rd(5'd16, 9, "R9");
    sw(5'd16, "R9");
    rd(5'd16, 9, "R9");

    // R6: random mix of mode changes, writes and reads
    for (int n = 0; n < N_RAND; n++) begin
      bit we, wen;
      logic [MW-1:0] nm, wm, rm;
      we  = ($urandom_range(0, 5) == 0);
      wen = ($urandom_range(0, 1) == 1);
      nm  = ($urandom_range(0, 9) == 0) ? 5'($urandom) : pick[$urandom_range(0, 13)];
      wm  = pick[$urandom_range(0, 13)];
      rm  = pick[$urandom_range(0, 13)];
      cyc(we, nm, wen, wm, int'($urandom_range(0, 15)), $urandom,
          rm, int'($urandom_range(0, 15)), "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule